// File: doc/BRIEF.md
# Offset-Sign Static Branch Predictor

This block is the fallback direction predictor in an instruction fetch pipeline. It looks at a decoded branch early in the pipeline. It makes a guess only when the dynamic target cache returned no prediction for that branch. The guess keeps no history: a branch whose offset is negative (it jumps backward) is predicted taken. A forward branch that carries a condition is predicted not taken. A forward branch with no condition is always taken, so it is predicted taken as well.

When the guess is "taken", the block computes the target as the branch PC plus the sign-extended byte offset. The redirect goes through one register, so the fetch unit sees it exactly one cycle after the branch was presented. That cycle is the refill bubble of a static taken prediction. The block works only when the global prediction enable is set, and only in the two fixed-width instruction-set modes. In the bytecode mode it does nothing. A flush input drops the branch that is presented at the same edge.

Top module: `sbp_predictor`

## Requirements
- R1: After reset, `redirect_o` is 0 and `redirect_pc_o` is 0.
- R2: When an eligible branch has an offset whose top bit is 1 (backward), `redirect_o` is 1 in the next cycle, whether or not `br_cond_i` is set.
- R3: When an eligible branch has `br_cond_i`=1 and an offset whose top bit is 0 (forward), `redirect_o` is 0 in the next cycle.
- R4: When an eligible branch has `br_cond_i`=0 and a forward offset, `redirect_o` is 1 in the next cycle.
- R5: In any cycle where `redirect_o` is 1, `redirect_pc_o` equals the PC of the branch from the previous cycle plus its offset sign-extended to the PC width, modulo 2^PC width.
- R6: A branch with `dyn_hit_i`=1 never produces a redirect.
- R7: A branch with `pred_en_i`=0 never produces a redirect.
- R8: The mode encoding is 0 = wide fixed-width, 1 = compact fixed-width, 2 = bytecode, 3 = reserved. Modes 0 and 1 predict. Modes 2 and 3 never produce a redirect.
- R9: A cycle with `br_valid_i`=0 never produces a redirect in the next cycle.
- R10: A branch presented while `flush_i`=1 produces no redirect in the next cycle.
- R11: The prediction is stateless. Back-to-back taken branches each produce a one-cycle redirect with their own target. A redirect drops to 0 in the cycle after, unless a new taken branch was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| flush_i | input | 1 | Drops the branch presented this cycle |
| pred_en_i | input | 1 | Global prediction enable |
| mode_i | input | 2 | Instruction-set mode (0 wide, 1 compact, 2 bytecode, 3 reserved) |
| dyn_hit_i | input | 1 | Dynamic predictor already predicted this branch |
| br_valid_i | input | 1 | A decoded branch is present |
| br_cond_i | input | 1 | The branch is conditional |
| pc_i | input | PC_W | Address of the branch |
| offset_i | input | OFF_W | Signed byte offset of the branch |
| redirect_o | output | 1 | Predicted-taken redirect, one cycle after the branch |
| redirect_pc_o | output | PC_W | Predicted target address |

## Verification
The assertions rely on two assumptions about the inputs. First, the branch fields are sampled only at the clock edge where `br_valid_i` is high. Second, the PC and offset of that edge are the values the target must match one cycle later. The stimulus meets both by changing every input on the falling edge and holding it across exactly one rising edge. It also waits for the internal reset release before presenting the first branch. Offsets are chosen on both sides of zero, and PCs are chosen so that some sums wrap around the top of the address space. This exercises the sign extension and the modular addition.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    ISA_WIDE     = 2'd0,
    ISA_COMPACT  = 2'd1,
    ISA_BYTECODE = 2'd2,
    ISA_RSVD     = 2'd3
  } isa_mode_e;
endpackage

// File: rtl/sbp_reset_sync.sv
module sbp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sbp_direction.sv
module sbp_direction
  import sbp_pkg::*;
(
  input  logic       br_valid_i,
  input  logic       br_cond_i,
  input  logic       offset_sign_i,
  input  logic [1:0] mode_i,
  input  logic       pred_en_i,
  input  logic       dyn_hit_i,
  output logic       take_o
);
  logic mode_ok;
  logic eligible;

  // Only the two fixed-width modes are handled; bytecode and reserved are off.
  always_comb begin
    case (mode_i)
      ISA_WIDE, ISA_COMPACT: mode_ok = 1'b1;
      default:               mode_ok = 1'b0;
    endcase
  end

  assign eligible = br_valid_i & pred_en_i & ~dyn_hit_i & mode_ok;
  // Backward: taken. Forward: taken only if unconditional.
  assign take_o   = eligible & (offset_sign_i | ~br_cond_i);
endmodule

// File: rtl/sbp_target.sv
module sbp_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 24
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [PC_W-1:0]  target_o
);
  logic [PC_W-1:0] off_ext;

  generate
    if (PC_W > OFF_W) begin : g_extend
      localparam int EXT_W = PC_W - OFF_W;
      assign off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    end else begin : g_trim
      assign off_ext = offset_i[PC_W-1:0];
    end
  endgenerate

  assign target_o = pc_i + off_ext;
endmodule

// File: rtl/sbp_redirect_reg.sv
module sbp_redirect_reg #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            flush_i,
  input  logic [PC_W-1:0] target_i,
  output logic            valid_o,
  output logic [PC_W-1:0] pc_o
);
  logic            valid_d, valid_q;
  logic [PC_W-1:0] pc_d, pc_q;
  logic            load_en;

  assign load_en = take_i & ~flush_i;

  always_comb begin
    valid_d = load_en;
    pc_d    = pc_q;
    if (load_en) pc_d = target_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
    end else begin
      valid_q <= valid_d;
      pc_q    <= pc_d;
    end
  end

  assign valid_o = valid_q;
  assign pc_o    = pc_q;

  // R10: a flushed cycle never yields a redirect on the next cycle
  p_flush_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !valid_o);

  // R11: target register holds while no redirect is loaded
  p_target_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(pc_o));
endmodule

// File: rtl/sbp_predictor.sv
module sbp_predictor
  import sbp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OFF_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             pred_en_i,
  input  logic [1:0]       mode_i,
  input  logic             dyn_hit_i,
  input  logic             br_valid_i,
  input  logic             br_cond_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o
);
  localparam int SIGN_BIT = OFF_W - 1;

  logic            rst_n_sync;
  logic            take;
  logic [PC_W-1:0] target;

  sbp_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sbp_direction u_dir (
    .br_valid_i    (br_valid_i),
    .br_cond_i     (br_cond_i),
    .offset_sign_i (offset_i[SIGN_BIT]),
    .mode_i        (mode_i),
    .pred_en_i     (pred_en_i),
    .dyn_hit_i     (dyn_hit_i),
    .take_o        (take)
  );

  sbp_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc_i     (pc_i),
    .offset_i (offset_i),
    .target_o (target)
  );

  sbp_redirect_reg #(.PC_W(PC_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .take_i   (take),
    .flush_i  (flush_i),
    .target_i (target),
    .valid_o  (redirect_o),
    .pc_o     (redirect_pc_o)
  );

  // R2: eligible backward branch redirects next cycle
  p_backward_taken_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (br_valid_i && pred_en_i && !dyn_hit_i && !flush_i && !mode_i[1] && offset_i[SIGN_BIT])
    |=> redirect_o);

  // R3: forward conditional branch never redirects
  p_fwd_cond_nt_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (br_cond_i && !offset_i[SIGN_BIT]) |=> !redirect_o);

  // R5: redirect target tracks the previous cycle's branch
  p_target_sum_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    redirect_o |-> (redirect_pc_o ==
      $past(pc_i) + PC_W'($signed($past(offset_i)))));

  // R6, R7, R9: redirect only follows a valid, enabled, dynamic-miss branch
  p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    redirect_o |-> $past(br_valid_i && pred_en_i && !dyn_hit_i));

  // R8: bytecode and reserved modes stay silent
  p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mode_i[1] |=> !redirect_o);
endmodule

// File: tb/sbp_predictor_test.sv
module sbp_predictor_test;
  localparam int PC_W  = 32;
  localparam int OFF_W = 24;

  logic             clk;
  logic             rst_n;
  logic             flush_i;
  logic             pred_en_i;
  logic [1:0]       mode_i;
  logic             dyn_hit_i;
  logic             br_valid_i;
  logic             br_cond_i;
  logic [PC_W-1:0]  pc_i;
  logic [OFF_W-1:0] offset_i;
  logic             redirect_o;
  logic [PC_W-1:0]  redirect_pc_o;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  sbp_predictor #(.PC_W(PC_W), .OFF_W(OFF_W)) uut (
    .clk (clk), .rst_n (rst_n), .flush_i (flush_i), .pred_en_i (pred_en_i),
    .mode_i (mode_i), .dyn_hit_i (dyn_hit_i), .br_valid_i (br_valid_i),
    .br_cond_i (br_cond_i), .pc_i (pc_i), .offset_i (offset_i),
    .redirect_o (redirect_o), .redirect_pc_o (redirect_pc_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [PC_W-1:0] exp_target(logic [PC_W-1:0] pc, logic [OFF_W-1:0] off);
    logic [PC_W-1:0] ext;
    ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
    return pc + ext;
  endfunction

  task automatic check(string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    flush_i = 0; pred_en_i = 1; mode_i = 2'd0; dyn_hit_i = 0;
    br_valid_i = 0; br_cond_i = 0; pc_i = '0; offset_i = '0;
  endtask

  // Present one branch for one edge, then check the registered result.
  task automatic branch(string req, logic v, logic c, logic [PC_W-1:0] pc,
                        logic [OFF_W-1:0] off, logic [1:0] m, logic en,
                        logic hit, logic fl, logic exp_take);
    @(negedge clk);
    br_valid_i = v; br_cond_i = c; pc_i = pc; offset_i = off;
    mode_i = m; pred_en_i = en; dyn_hit_i = hit; flush_i = fl;
    @(posedge clk); #1;
    check(req, "redirect", PC_W'(redirect_o), PC_W'(exp_take));
    if (exp_take) check(req, "target", redirect_pc_o, exp_target(pc, off));
  endtask

  task automatic quiet_cycle(string req);
    @(negedge clk);
    idle_inputs();
    @(posedge clk); #1;
    check(req, "redirect after idle", PC_W'(redirect_o), '0);
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "redirect in reset", PC_W'(redirect_o), '0);
    check("R1", "target in reset", redirect_pc_o, '0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_backward_r2();
    branch("R2", 1, 1, 32'h0000_1000, 24'hFF_FFF0, 2'd0, 1, 0, 0, 1);
    branch("R2", 1, 0, 32'h0000_2000, 24'h80_0000, 2'd1, 1, 0, 0, 1);
    quiet_cycle("R11");
  endtask

  task automatic t_forward_r3_r4();
    branch("R3", 1, 1, 32'h0000_3000, 24'h00_0040, 2'd0, 1, 0, 0, 0);
    branch("R3", 1, 1, 32'h0000_3000, 24'h7F_FFFF, 2'd1, 1, 0, 0, 0);
    branch("R4", 1, 0, 32'h0000_4000, 24'h00_0100, 2'd0, 1, 0, 0, 1);
    quiet_cycle("R11");
  endtask

  task automatic t_target_r5();
    branch("R5", 1, 0, 32'hFFFF_FF00, 24'h00_0200, 2'd0, 1, 0, 0, 1); // wraps up
    branch("R5", 1, 1, 32'h0000_0010, 24'hFF_FF00, 2'd1, 1, 0, 0, 1); // wraps down
    quiet_cycle("R11");
  endtask

  task automatic t_gates_r6_r7_r9();
    branch("R6", 1, 1, 32'h0000_5000, 24'hFF_FFFC, 2'd0, 1, 1, 0, 0);
    branch("R7", 1, 0, 32'h0000_5000, 24'hFF_FFFC, 2'd0, 0, 0, 0, 0);
    branch("R9", 0, 0, 32'h0000_5000, 24'hFF_FFFC, 2'd0, 1, 0, 0, 0);
  endtask

  task automatic t_modes_r8();
    branch("R8", 1, 0, 32'h0000_6000, 24'hFF_FF00, 2'd2, 1, 0, 0, 0);
    branch("R8", 1, 0, 32'h0000_6000, 24'hFF_FF00, 2'd3, 1, 0, 0, 0);
    branch("R8", 1, 0, 32'h0000_6000, 24'hFF_FF00, 2'd1, 1, 0, 0, 1);
    quiet_cycle("R11");
  endtask

  task automatic t_flush_r10();
    branch("R10", 1, 0, 32'h0000_7000, 24'hFF_FFF8, 2'd0, 1, 0, 1, 0);
    branch("R10", 1, 0, 32'h0000_7100, 24'hFF_FFF8, 2'd0, 1, 0, 0, 1);
    quiet_cycle("R10");
  endtask

  task automatic t_stateless_r11();
    branch("R11", 1, 1, 32'h0000_8000, 24'hFF_FFF0, 2'd0, 1, 0, 0, 1);
    branch("R11", 1, 1, 32'h0000_9000, 24'h00_0010, 2'd0, 1, 0, 0, 0);
    branch("R11", 1, 1, 32'h0000_A000, 24'hFF_FF00, 2'd0, 1, 0, 0, 1);
    branch("R11", 1, 0, 32'h0000_B000, 24'h00_0020, 2'd1, 1, 0, 0, 1);
    quiet_cycle("R11");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_backward_r2();
    t_forward_r3_r4();
    t_target_r5();
    t_gates_r6_r7_r9();
    t_modes_r8();
    t_flush_r10();
    t_stateless_r11();
    finish_run();
  end
endmodule